// File: doc/BRIEF.md
# Multi-lane SPI shift engine

This block is the master-side serial shift engine of a SPI controller. It moves one data word per transfer over one, two or four bidirectional data lines. A write strobe on the transmit port starts a transfer. The engine then produces a serial clock that idles low: output lines change while the clock is low, and input lines are sampled on each rising edge. After the last falling edge, the assembled receive word is loaded into the receive register and a one-cycle done pulse is raised.

The line-width mode, the direction of the multi-line modes, the clock count and the bit order are taken from the configuration inputs on the cycle the transfer starts. They are held for the rest of the transfer. In single-line mode the engine works as a classic full-duplex SPI. In dual-line and quad-line modes it only transmits or only receives. In those modes the lines it does not drive have their enables released.

Top module: `mlspi_engine`

## Requirements
- R1: Single-line mode (cfg_mode 0, and the spare code 3) drives only sdio_o[0] with sdio_oe = 4'b0001 while busy, samples receive bits from sdio_i[1], and ignores the direction bit.
- R2: Dual-line mode (cfg_mode 1) carries data on lines 1:0. With cfg_dir_in = 0 it drives sdio_oe = 4'b0011 while busy. With cfg_dir_in = 1 it drives no line and samples sdio_i[1:0].
- R3: Quad-line mode (cfg_mode 2) carries data on lines 3:0. With cfg_dir_in = 0 it drives sdio_oe = 4'b1111 while busy. With cfg_dir_in = 1 it drives no line and samples sdio_i[3:0].
- R4: A clock-count value N gives N+1 serial clock pulses, capped at DATA_W divided by the lane count (16, 8 or 4 for the default width). A transfer of C clocks moves L = C × lanes bits.
- R5: sclk is low whenever the engine is idle. With the write sampled at clock edge t0, sclk rises at t0+SCLK_HALF, stays high and low for SCLK_HALF cycles each, and done is raised at edge t0+2·SCLK_HALF·C.
- R6: MSB-first order (cfg_lsb_first = 0): during serial clock k (counting from 0) with w lanes, line j carries word bit L − w·(k+1) + j. In a 16-bit quad transfer, the first clock puts bits 15..12 on lines 3..0.
- R7: LSB-first order (cfg_lsb_first = 1): during serial clock k, line j carries word bit k·w + w − 1 − j. In a 16-bit quad transfer, the first clock puts bits 0..3 on lines 3..0. In single-line mode, bit 0 goes out first.
- R8: The received word is built with the same bit mapping as the transmit word, and bits at L and above are zero. A multi-line transfer in the transmit direction loads zero. rxd_data changes only on the cycle done is high.
- R9: busy is high from the cycle after an accepted write until done. done is a single-cycle pulse raised on the cycle busy falls.
- R10: A write while busy is ignored, including a write on the same edge that ends the transfer. A write on the very next edge starts a new transfer.
- R11: After reset, sclk, busy, done, sdio_oe, sdio_o and rxd_data are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Line width: 0 single, 1 dual, 2 quad, 3 single |
| cfg_dir_in | input | 1 | Multi-line direction: 0 transmit, 1 receive |
| cfg_clk_cnt | input | CNT_W | Clock count minus one |
| cfg_lsb_first | input | 1 | 1 selects LSB-first order |
| txd_wr | input | 1 | Write strobe for the transmit word; starts a transfer |
| txd_data | input | DATA_W | Transmit word |
| rxd_data | output | DATA_W | Receive register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when rxd_data updates |
| sclk | output | 1 | Serial clock, idle low |
| sdio_i | input | 4 | Data line inputs |
| sdio_o | output | 4 | Data line output values |
| sdio_oe | output | 4 | Data line output enables |

## Verification
Two events can land on the same clock edge: the end of a transfer (the last falling sclk edge, which loads rxd_data and raises done) and a new transmit write. The bench drives txd_wr so that it is sampled on exactly that edge. It then checks that the completing transfer still delivers the expected word, that busy stays low and that sclk stays idle afterwards. In other sweeps it issues the next write on the edge right after done and checks that this write is accepted and the new transfer runs normally.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

    typedef enum logic [1:0] {
        LANE_X1   = 2'd0,
        LANE_X2   = 2'd1,
        LANE_X4   = 2'd2,
        LANE_RSVD = 2'd3
    } lane_mode_e;

    // log2 of the number of active lanes for a mode code
    function automatic logic [1:0] lane_shift(input logic [1:0] mode);
        case (lane_mode_e'(mode))
            LANE_X2: return 2'd1;
            LANE_X4: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // enable pattern of the active lanes of a multi-line mode
    function automatic logic [3:0] lane_mask(input logic [1:0] shamt);
        case (shamt)
            2'd1:    return 4'b0011;
            2'd2:    return 4'b1111;
            default: return 4'b0001;
        endcase
    endfunction

endpackage

// File: rtl/mlspi_sclk_gen.sv
module mlspi_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          sclk;
    } gen_t;

    gen_t gen_d, gen_q;
    logic half_end;

    always_comb begin
        gen_d    = gen_q;
        half_end = (gen_q.cnt == DW'(HALF_DIV - 1));
        if (!run) begin
            gen_d.cnt  = '0;
            gen_d.sclk = 1'b0;
        end else if (half_end) begin
            gen_d.cnt  = '0;
            gen_d.sclk = ~gen_q.sclk;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sclk     = gen_q.sclk;
    assign rise_stb = run && half_end && !gen_q.sclk;
    assign fall_stb = run && half_end &&  gen_q.sclk;

endmodule

// File: rtl/mlspi_lane_map.sv
module mlspi_lane_map #(
    parameter int DATA_W = 16,
    parameter int IDXW   = $clog2(DATA_W)
) (
    input  logic [1:0]             shamt,
    input  logic                   lsb_first,
    input  logic [IDXW-1:0]        len,
    input  logic [IDXW-1:0]        clk_idx,
    input  logic [DATA_W-1:0]      tx_word,
    output logic [3:0]             lane_bit,
    output logic [3:0]             lane_ok,
    output logic [3:0][IDXW-1:0]   lane_pos
);
    // Arithmetic is modulo 2**IDXW; DATA_W is a power of two, so a length
    // equal to DATA_W wraps to zero without changing any valid position.
    logic [IDXW-1:0] base;
    logic [IDXW-1:0] step;

    assign base = clk_idx << shamt;
    assign step = IDXW'(1) << shamt;

    for (genvar j = 0; j < 4; j++) begin : g_lane
        logic [IDXW-1:0] pos;
        always_comb begin
            if (lsb_first) pos = base + step - IDXW'(1) - IDXW'(j);
            else           pos = len - base - step + IDXW'(j);
        end
        assign lane_ok[j]  = (3'(j) < (3'd1 << shamt));
        assign lane_pos[j] = pos;
        assign lane_bit[j] = lane_ok[j] ? tx_word[pos] : 1'b0;
    end

endmodule

// File: rtl/mlspi_engine.sv
module mlspi_engine #(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 4,
    parameter int SCLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_dir_in,
    input  logic [CNT_W-1:0]  cfg_clk_cnt,
    input  logic              cfg_lsb_first,
    input  logic              txd_wr,
    input  logic [DATA_W-1:0] txd_data,
    output logic [DATA_W-1:0] rxd_data,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    input  logic [3:0]        sdio_i,
    output logic [3:0]        sdio_o,
    output logic [3:0]        sdio_oe
);
    import mlspi_pkg::*;

    localparam int IDXW = $clog2(DATA_W);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDXW-1:0]   k;
        logic [IDXW-1:0]   last_k;
        logic [IDXW-1:0]   len;
        logic [1:0]        shamt;
        logic              single;
        logic              rx_en;
        logic              drive;
        logic              lsb;
        logic [DATA_W-1:0] tx_word;
        logic [DATA_W-1:0] rx_work;
        logic [DATA_W-1:0] rxd;
    } eng_t;

    eng_t st_d, st_q;

    logic              rise_stb, fall_stb;
    logic [3:0]        lane_bit, lane_ok;
    logic [3:0][IDXW-1:0] lane_pos;
    logic [3:0]        rx_src;
    logic [1:0]        sh_new;
    logic [31:0]       n_clk;

    // clocks for a count value, capped by the lanes of the mode
    function automatic logic [31:0] clocks_for(input logic [CNT_W-1:0] cnt,
                                               input logic [1:0] sh);
        logic [31:0] want, cap;
        want = 32'(cnt) + 32'd1;
        cap  = 32'(DATA_W) >> sh;
        return (want > cap) ? cap : want;
    endfunction

    mlspi_sclk_gen #(.HALF_DIV(SCLK_HALF)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.busy),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mlspi_lane_map #(.DATA_W(DATA_W), .IDXW(IDXW)) u_map (
        .shamt     (st_q.shamt),
        .lsb_first (st_q.lsb),
        .len       (st_q.len),
        .clk_idx   (st_q.k),
        .tx_word   (st_q.tx_word),
        .lane_bit  (lane_bit),
        .lane_ok   (lane_ok),
        .lane_pos  (lane_pos)
    );

    // single-line receive always enters on line 1
    assign rx_src = st_q.single ? {4{sdio_i[1]}} : sdio_i;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sh_new    = lane_shift(cfg_mode);
        n_clk     = clocks_for(cfg_clk_cnt, sh_new);

        if (!st_q.busy) begin
            if (txd_wr) begin
                st_d.busy    = 1'b1;
                st_d.k       = '0;
                st_d.last_k  = IDXW'(n_clk - 32'd1);
                st_d.len     = IDXW'(n_clk << sh_new);
                st_d.shamt   = sh_new;
                st_d.single  = (sh_new == 2'd0);
                st_d.rx_en   = (sh_new == 2'd0) || cfg_dir_in;
                st_d.drive   = (sh_new == 2'd0) || !cfg_dir_in;
                st_d.lsb     = cfg_lsb_first;
                st_d.tx_word = txd_data;
                st_d.rx_work = '0;
            end
        end else begin
            if (rise_stb && st_q.rx_en) begin
                for (int j = 0; j < 4; j++) begin
                    if (lane_ok[j]) st_d.rx_work[lane_pos[j]] = rx_src[j];
                end
            end
            if (fall_stb) begin
                if (st_q.k == st_q.last_k) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.rxd  = st_q.rx_work;
                end else begin
                    st_d.k = st_q.k + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.busy && st_q.drive)
            sdio_oe = st_q.single ? 4'b0001 : lane_mask(st_q.shamt);
        else
            sdio_oe = 4'b0000;
        sdio_o = (st_q.single ? {3'b000, lane_bit[0]} : lane_bit) & sdio_oe;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign rxd_data = st_q.rxd;

endmodule

// File: rtl/mlspi_engine_chk.sv
module mlspi_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd_wr,
    input logic              busy,
    input logic              done,
    input logic              sclk,
    input logic [3:0]        sdio_oe,
    input logic [DATA_W-1:0] rxd_data
);
    p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    p_lines_released_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sdio_oe == 4'b0000));

    p_enable_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe == 4'b0000) || (sdio_oe == 4'b0001) ||
        (sdio_oe == 4'b0011) || (sdio_oe == 4'b1111));

    p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_idle_write_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && txd_wr) |=> (busy && !sclk));

    p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && txd_wr) |=> (busy || done));

    p_rxd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rxd_data));

endmodule

bind mlspi_engine mlspi_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd_wr   (txd_wr),
    .busy     (busy),
    .done     (done),
    .sclk     (sclk),
    .sdio_oe  (sdio_oe),
    .rxd_data (rxd_data)
);

// File: tb/tb_mlspi_engine.sv
module tb_mlspi_engine;
    localparam int DW   = 16;
    localparam int CW   = 4;
    localparam int HALF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic          cfg_dir_in = 1'b0;
    logic [CW-1:0] cfg_clk_cnt = '0;
    logic          cfg_lsb_first = 1'b0;
    logic          txd_wr = 1'b0;
    logic [DW-1:0] txd_data = '0;
    logic [DW-1:0] rxd_data;
    logic          busy, done, sclk;
    logic [3:0]    sdio_i = '0;
    logic [3:0]    sdio_o, sdio_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mlspi_engine #(.DATA_W(DW), .CNT_W(CW), .SCLK_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dir_in(cfg_dir_in),
        .cfg_clk_cnt(cfg_clk_cnt), .cfg_lsb_first(cfg_lsb_first),
        .txd_wr(txd_wr), .txd_data(txd_data), .rxd_data(rxd_data),
        .busy(busy), .done(done), .sclk(sclk),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
    );

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bit_pos(int r, int j, int w, int len, bit lsb);
        if (lsb) return r * w + w - 1 - j;
        return len - w * (r + 1) + j;
    endfunction

    task automatic drive_in(int r, int w, int c, int len, bit lsb, bit single, logic [DW-1:0] rxw);
        logic [3:0] v;
        v = 4'($urandom);
        if (r < c) begin
            if (single) v[1] = rxw[bit_pos(r, 0, 1, len, lsb)];
            else for (int j = 0; j < w; j++) v[j] = rxw[bit_pos(r, j, w, len, lsb)];
        end
        sdio_i = v;
    endtask

    task automatic run_xfer(int mode, bit dir, bit lsb, int n, logic [DW-1:0] tx,
                            logic [DW-1:0] rxw, bit poke_busy, bit poke_done);
        int w = (mode == 1) ? 2 : ((mode == 2) ? 4 : 1);
        bit single = (mode == 0) || (mode == 3);
        int c = ((n + 1) > (DW / w)) ? (DW / w) : (n + 1);
        int len = c * w;
        int t_done = 2 * HALF * c + 1;
        int rises = 0;
        bit prev = 1'b0;
        bit seen = 1'b0;
        string rq = single ? "R1" : ((mode == 1) ? "R2" : "R3");
        string oq = lsb ? "R7" : "R6";
        logic [DW-1:0] exp_rx, lmask;
        logic [3:0] exp_oe, exp_o;

        lmask  = (len >= DW) ? {DW{1'b1}} : DW'((32'd1 << len) - 32'd1);
        exp_rx = (single || dir) ? (rxw & lmask) : '0;
        exp_oe = single ? 4'b0001 : (dir ? 4'b0000 : 4'((32'd1 << w) - 32'd1));

        cfg_mode = 2'(mode); cfg_dir_in = dir; cfg_clk_cnt = CW'(n);
        cfg_lsb_first = lsb; txd_data = tx; txd_wr = 1'b1;
        drive_in(0, w, c, len, lsb, single, rxw);
        @(negedge clk);
        txd_wr = 1'b0;
        for (int cyc = 1; (cyc <= t_done + 4) && !seen; cyc++) begin
            if (sclk && !prev) begin
                rises++;
                exp_o = '0;
                if (exp_oe != 4'b0000 && rises <= c)
                    for (int j = 0; j < w; j++) exp_o[j] = tx[bit_pos(rises - 1, j, w, len, lsb)];
                check(sdio_oe == exp_oe, rq, "line enables", 32'(sdio_oe), 32'(exp_oe));
                check(sdio_o == exp_o, oq, "line values", 32'(sdio_o), 32'(exp_o));
                drive_in(rises, w, c, len, lsb, single, rxw);
            end
            prev = sclk;
            if (poke_busy && cyc == 3) begin
                txd_wr = 1'b1; txd_data = ~tx;              // R10 write while busy
            end else if (poke_done && cyc == t_done - 1) begin
                txd_wr = 1'b1; txd_data = ~tx;              // R10 write on the ending edge
            end else begin
                txd_wr = 1'b0;
            end
            if (done) begin
                seen = 1'b1;
                check(cyc == t_done, "R5", "done cycle", 32'(cyc), 32'(t_done));
                check(rises == c, "R4", "sclk pulses", 32'(rises), 32'(c));
                check(rxd_data == exp_rx, "R8", "received word", 32'(rxd_data), 32'(exp_rx));
                check(!busy, "R9", "busy at done", 32'(busy), 32'd0);
            end
            if (!seen) @(negedge clk);
        end
        if (!seen) check(1'b0, "R9", "done pulse missing", 32'd0, 32'd1);
        if (poke_done) begin
            repeat (3) @(negedge clk);
            check(!busy && !sclk, "R10", "write on ending edge started a transfer",
                  32'({busy, sclk}), 32'd0);
            check(rxd_data == exp_rx, "R10", "receive word after ignored write",
                  32'(rxd_data), 32'(exp_rx));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sclk == 1'b0, "R11", "sclk in reset", 32'(sclk), 32'd0);
        check(busy == 1'b0 && done == 1'b0, "R11", "busy/done in reset", 32'({busy, done}), 32'd0);
        check(sdio_oe == 4'b0000 && sdio_o == 4'b0000, "R11", "lines in reset",
              32'({sdio_oe, sdio_o}), 32'd0);
        check(rxd_data == '0, "R11", "receive register in reset", 32'(rxd_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !sclk, "R11", "idle after reset", 32'({busy, sclk}), 32'd0);
        for (int m = 0; m < 4; m++)
            for (int d = 0; d < 2; d++)
                for (int l = 0; l < 2; l++)
                    for (int n = 0; n < 16; n++) begin
                        logic [DW-1:0] tx, rx;
                        tx = DW'(32'hA5C3 ^ (n * 32'h1357) ^ (m * 32'h0F0F) ^ (d * 32'h8001) ^ (l * 32'h0660));
                        rx = DW'(32'h3C96 ^ (n * 32'h2469) ^ (m * 32'hF00F) ^ (l * 32'h1111) ^ (d * 32'h4242));
                        run_xfer(m, d[0], l[0], n, tx, rx, (n % 3) == 0, (n % 4) == 1);
                    end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule